// File: doc/BRIEF.md
# Mouse Coordinate Updater

This block turns a mouse movement code into a one-step change of a cursor position held in memory. On each start strobe it takes the low four bits of the movement input and looks them up in a fixed nine-entry table. The table gives a horizontal and a vertical step, each -1, 0 or +1, and covers diagonal as well as straight moves.

When the code means movement, the block reads the two-word position record from memory, horizontal word first and vertical word second. It adds the steps and writes both words back in the same order. When the code means no movement, the block makes no memory access and reports completion at once.

The memory side uses a request/acknowledge pair with only one request open at a time. A single-cycle done pulse marks the end of every accepted command.

Top module: `mouse_coord_updater`

## Requirements
- R1: While reset is asserted and right after it is released, done_o, mem_rd_o and mem_wr_o are all low.
- R2: Only bits [3:0] of move_i select the movement. Higher bits have no effect on the steps or on the memory traffic.
- R3: Codes 0 and 9 to 15 mean no movement. Such a command makes no memory access, and done_o is high in the cycle after the start strobe is sampled.
- R4: Codes 1 to 8 give (dY,dX) as follows: 1=(-1,0), 2=(+1,0), 3=(0,-1), 4=(-1,-1), 5=(+1,-1), 6=(0,+1), 7=(-1,+1), 8=(+1,+1).
- R5: A move first reads address BASE (the X word) and then reads BASE+1 (the Y word).
- R6: After the reads, the block writes old X + dX to BASE and then old Y + dY to BASE+1.
- R7: Coordinates are 16-bit two's-complement values. A sum that overflows wraps without saturating, so 16'hFFFF+1 gives 0 and 16'h8000-1 gives 16'h7FFF.
- R8: done_o is high for one cycle, in the cycle after the acknowledge of the BASE+1 write. With a one-cycle gap between a request and its acknowledge, this is 7 cycles after the first read request appears.
- R9: At most one request is open at a time: mem_rd_o and mem_wr_o are never high together, and a request keeps its address until it is acknowledged. A start strobe that arrives while a move is in progress is ignored.
- R10: A start strobe in the same cycle that done_o is high is accepted as a new command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe; takes effect only when the block is idle |
| move_i | input | IN_W | Movement code; only bits [3:0] are used |
| mem_addr_o | output | AW | Memory word address |
| mem_rd_o | output | 1 | Read request, held until acknowledged |
| mem_wr_o | output | 1 | Write request, held until acknowledged |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid together with mem_ack_i |
| mem_ack_i | input | 1 | Request acknowledge |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the completion pulse of one command and the start strobe of the next. The bench waits for done_o and raises start_i in that very cycle. It then expects the new command's read sequence, or its immediate done pulse for a no-move code, to follow without a lost cycle. It also raises start_i partway through a move. In that case the scoreboard must see no extra memory access, and the stored coordinates must hold only the first command's result.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_X,
    ST_RD_Y,
    ST_WR_X,
    ST_WR_Y
  } mcu_state_e;

  typedef struct packed {
    logic signed [1:0] dx;
    logic signed [1:0] dy;
  } mcu_step_t;
endpackage

// File: rtl/mcu_decode.sv
module mcu_decode
  import mcu_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output mcu_step_t         step_o,
  output logic              moves_o
);
  always_comb begin
    moves_o   = 1'b1;
    step_o.dx = 2'sd0;
    step_o.dy = 2'sd0;
    case (code_i)
      4'd1: step_o.dy = -2'sd1;
      4'd2: step_o.dy = 2'sd1;
      4'd3: step_o.dx = -2'sd1;
      4'd4: begin step_o.dx = -2'sd1; step_o.dy = -2'sd1; end
      4'd5: begin step_o.dx = -2'sd1; step_o.dy = 2'sd1;  end
      4'd6: step_o.dx = 2'sd1;
      4'd7: begin step_o.dx = 2'sd1;  step_o.dy = -2'sd1; end
      4'd8: begin step_o.dx = 2'sd1;  step_o.dy = 2'sd1;  end
      default: moves_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mcu_ctrl.sv
module mcu_ctrl
  import mcu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic moves_i,
  input  logic ack_i,
  output logic accept_o,
  output logic rd_o,
  output logic wr_o,
  output logic sel_y_o,
  output logic cap_x_o,
  output logic cap_y_o,
  output logic done_o
);
  mcu_state_e state_q, state_d;
  logic       done_q, done_d;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign rd_o     = (state_q == ST_RD_X) || (state_q == ST_RD_Y);
  assign wr_o     = (state_q == ST_WR_X) || (state_q == ST_WR_Y);
  assign sel_y_o  = (state_q == ST_RD_Y) || (state_q == ST_WR_Y);
  assign cap_x_o  = (state_q == ST_RD_X) && ack_i;
  assign cap_y_o  = (state_q == ST_RD_Y) && ack_i;
  assign done_o   = done_q;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        if (moves_i) state_d = ST_RD_X;
        else         done_d  = 1'b1;
      end
      ST_RD_X: if (ack_i) state_d = ST_RD_Y;
      ST_RD_Y: if (ack_i) state_d = ST_WR_X;
      ST_WR_X: if (ack_i) state_d = ST_WR_Y;
      ST_WR_Y: if (ack_i) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/mouse_coord_updater.sv
module mouse_coord_updater
  import mcu_pkg::*;
#(
  parameter int           IN_W = 8,
  parameter int           AW   = 16,
  parameter int           DW   = 16,
  parameter logic [AW-1:0] BASE = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [IN_W-1:0] move_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          done_o
);
  localparam int NAXES = 2;

  logic [CODE_W-1:0]      code_w;
  mcu_step_t              step_w, step_q;
  logic                   moves_w, accept_w, sel_y_w;
  logic [NAXES-1:0]       cap_w;
  logic signed [1:0]      step_axis [NAXES];
  logic [DW-1:0]          coord_q [NAXES];

  assign code_w = move_i[CODE_W-1:0];

  mcu_decode u_decode (
    .code_i  (code_w),
    .step_o  (step_w),
    .moves_o (moves_w)
  );

  mcu_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .moves_i  (moves_w),
    .ack_i    (mem_ack_i),
    .accept_o (accept_w),
    .rd_o     (mem_rd_o),
    .wr_o     (mem_wr_o),
    .sel_y_o  (sel_y_w),
    .cap_x_o  (cap_w[0]),
    .cap_y_o  (cap_w[1]),
    .done_o   (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else if (accept_w) begin
      step_q <= step_w;
    end
  end

  assign step_axis[0] = step_q.dx;
  assign step_axis[1] = step_q.dy;

  for (genvar a = 0; a < NAXES; a++) begin : g_axis
    logic [DW-1:0] sum_w;
    assign sum_w = mem_rdata_i + {{(DW-2){step_axis[a][1]}}, step_axis[a]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        coord_q[a] <= '0;
      end else if (cap_w[a]) begin
        coord_q[a] <= sum_w;
      end
    end
  end

  assign mem_addr_o  = BASE + AW'(sel_y_w);
  assign mem_wdata_o = sel_y_w ? coord_q[1] : coord_q[0];
endmodule

// File: rtl/mcu_checker.sv
module mcu_checker #(
  parameter int            AW   = 16,
  parameter logic [AW-1:0] BASE = 16'h0100
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic          mem_ack_i,
  input logic          done_o
);
  always_comb begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!done_o && !mem_rd_o && !mem_wr_o);
    end
  end

  a_r9_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  a_r9_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd_o || mem_wr_o) && !mem_ack_i) |=>
      ((mem_rd_o || mem_wr_o) && $stable(mem_addr_o)));

  a_r5_read_x_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_o) |-> (mem_addr_o == BASE));

  a_r6_write_x_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_o) |-> (mem_addr_o == BASE));

  a_r8_done_after_y_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_o && mem_ack_i && (mem_addr_o == BASE + AW'(1))) |=> done_o);

  a_r3_no_access_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!mem_rd_o && !mem_wr_o));
endmodule

bind mouse_coord_updater mcu_checker #(.AW(AW), .BASE(BASE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_addr_o (mem_addr_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .mem_ack_i  (mem_ack_i),
  .done_o     (done_o)
);

// File: tb/mouse_coord_updater_bench.sv
module mouse_coord_updater_bench;
  localparam logic [15:0] BASE = 16'h0100;

  typedef struct {
    logic [15:0] addr;
    logic        wr;
    logic [15:0] data;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  move_i;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        mem_rd_o, mem_wr_o, mem_ack_i, done_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  item_t exp_q[$];
  logic [15:0] mem [2];

  always #2 clk = ~clk;

  mouse_coord_updater #(.IN_W(8), .AW(16), .DW(16), .BASE(BASE)) u_mouse_coord_updater (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .move_i(move_i),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .mem_ack_i(mem_ack_i), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void ref_step(input logic [7:0] code, output int dx, output int dy, output bit mv);
    dx = 0; dy = 0; mv = 1'b1;
    case (code[3:0])
      4'd1: dy = -1;
      4'd2: dy = 1;
      4'd3: dx = -1;
      4'd4: begin dx = -1; dy = -1; end
      4'd5: begin dx = -1; dy = 1; end
      4'd6: dx = 1;
      4'd7: begin dx = 1; dy = -1; end
      4'd8: begin dx = 1; dy = 1; end
      default: mv = 1'b0;
    endcase
  endfunction

  // memory model and monitor: pops expected accesses
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
      end else if (mem_rd_o || mem_wr_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected access", {16'h0, mem_addr_o}, 32'h0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check(mem_addr_o == it.addr, "R5/R6 access address", {16'h0, mem_addr_o}, {16'h0, it.addr});
          check(mem_wr_o == it.wr, "R5/R6 access kind", {31'h0, mem_wr_o}, {31'h0, it.wr});
          if (it.wr)
            check(mem_wdata_o == it.data, "R6/R7 write data", {16'h0, mem_wdata_o}, {16'h0, it.data});
        end
        if (mem_addr_o == BASE || mem_addr_o == BASE + 16'd1) begin
          if (mem_rd_o) mem_rdata_i = mem[mem_addr_o - BASE];
          else          mem[mem_addr_o - BASE] = mem_wdata_o;
        end
        mem_ack_i = 1'b1;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // driver: preload record, push expectations, pulse start (called right after a negedge)
  task automatic launch(input logic [7:0] code, input logic [15:0] x0, input logic [15:0] y0);
    int dx, dy; bit mv;
    item_t it;
    ref_step(code, dx, dy, mv);
    mem[0] = x0; mem[1] = y0;
    if (mv) begin
      it.addr = BASE;        it.wr = 1'b0; it.data = 16'h0;           exp_q.push_back(it);
      it.addr = BASE + 16'd1; it.wr = 1'b0; it.data = 16'h0;           exp_q.push_back(it);
      it.addr = BASE;        it.wr = 1'b1; it.data = x0 + 16'(dx);    exp_q.push_back(it);
      it.addr = BASE + 16'd1; it.wr = 1'b1; it.data = y0 + 16'(dy);    exp_q.push_back(it);
    end
    start_i = 1'b1; move_i = code;
    @(negedge clk);
    start_i = 1'b0; move_i = 8'hA5;
  endtask

  // wait for completion; returns at the negedge where done_o is high
  task automatic await(input logic [7:0] code, input logic [15:0] x0, input logic [15:0] y0,
                       input bit poke_busy, input string req);
    int dx, dy; bit mv; int cnt;
    ref_step(code, dx, dy, mv);
    cnt = 0;
    while (!done_o && cnt < 30) begin
      if (poke_busy && cnt == 2) begin start_i = 1'b1; move_i = 8'h01; end
      if (poke_busy && cnt == 3) begin start_i = 1'b0; move_i = 8'hA5; end
      @(negedge clk);
      cnt++;
    end
    check(cnt == (mv ? 7 : 0), {req, " done latency (R3/R8)"}, cnt, mv ? 7 : 0);
    check(exp_q.size() == 0, {req, " all accesses seen (R5/R6)"}, exp_q.size(), 0);
    check(mem[0] == (mv ? x0 + 16'(dx) : x0), {req, " X word"}, {16'h0, mem[0]}, {16'h0, mv ? x0 + 16'(dx) : x0});
    check(mem[1] == (mv ? y0 + 16'(dy) : y0), {req, " Y word"}, {16'h0, mem[1]}, {16'h0, mv ? y0 + 16'(dy) : y0});
  endtask

  task automatic single(input logic [7:0] code, input logic [15:0] x0, input logic [15:0] y0, input string req);
    launch(code, x0, y0);
    await(code, x0, y0, 1'b0, req);
    @(negedge clk);
    check(done_o == 1'b0, {req, " done one cycle (R8)"}, {31'h0, done_o}, 32'h0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; move_i = 8'h00;
    mem_ack_i = 1'b0; mem_rdata_i = 16'h0;
    mem[0] = 16'h0; mem[1] = 16'h0;
    repeat (3) @(negedge clk);
    check(!done_o && !mem_rd_o && !mem_wr_o, "R1 reset outputs quiet", {29'h0, done_o, mem_rd_o, mem_wr_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done_o && !mem_rd_o && !mem_wr_o, "R1 quiet after release", {29'h0, done_o, mem_rd_o, mem_wr_o}, 32'h0);

    // R4 table, all eight movement codes
    for (int c = 1; c <= 8; c++) single(8'(c), 16'h1234, 16'h4321, "R4 table");
    // R3 no-move codes
    single(8'h00, 16'h0005, 16'h0006, "R3 code 0");
    for (int c = 9; c <= 15; c++) single(8'(c), 16'h0007, 16'h0008, "R3 codes 9-15");
    // R2 upper bits ignored
    single(8'hF2, 16'h0100, 16'h0200, "R2 upper bits with code 2");
    single(8'h19, 16'h0100, 16'h0200, "R2 upper bits with code 9");
    single(8'h30, 16'h0100, 16'h0200, "R2 upper bits with code 0");
    // R7 wrap
    single(8'h06, 16'hFFFF, 16'h0000, "R7 X wrap up");
    single(8'h01, 16'h0000, 16'h8000, "R7 Y wrap down");
    single(8'h05, 16'h0000, 16'h7FFF, "R7 both wrap");

    // R9 start while busy is ignored
    launch(8'h08, 16'h0010, 16'h0020);
    await(8'h08, 16'h0010, 16'h0020, 1'b1, "R9 busy start");
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0 && !mem_rd_o && !mem_wr_o, "R9 no extra access", exp_q.size(), 0);

    // R10 start in the cycle done is high
    launch(8'h07, 16'h0aaa, 16'h0bbb);
    await(8'h07, 16'h0aaa, 16'h0bbb, 1'b0, "R10 first move");
    launch(8'h04, 16'h0ccc, 16'h0ddd);
    await(8'h04, 16'h0ccc, 16'h0ddd, 1'b0, "R10 chained move");
    launch(8'h00, 16'h0001, 16'h0002);
    await(8'h00, 16'h0001, 16'h0002, 1'b0, "R10 chained no-move");
    @(negedge clk);
    check(done_o == 1'b0, "R10 done drops", {31'h0, done_o}, 32'h0);

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule